// File: doc/BRIEF.md
# Synchronous PWM Update-Period Controller

This block serves a group of PWM channels that run from one shared period counter. It decides the clock cycle in which freshly prepared duty-cycle values are handed to those channels. In the automatic methods, handovers happen only at update boundaries. Boundaries are spaced a programmable number of whole PWM periods apart. Software picks one of three methods: fully manual, manually written values with an automatic trigger, or automatically written values with an automatic trigger.

The spacing can be changed while the channels keep running. A new spacing goes into a staging register and waits there. It becomes the live spacing only when an update boundary and the end of a PWM period happen in the same cycle. From then on it governs the count that follows. An external strobe marks each end of PWM period. The block answers with a one-cycle handover strobe, and with a one-cycle flag whenever the staged spacing has been taken over.

Top module: `uprd_ctrl`

## Requirements
- R1: After a synchronous reset the mode is manual (0), no channel is grouped, the live spacing is 0, nothing is staged, the period count is 0 and the ready bit is clear. Both outputs are low.
- R2: Writes go through `wr_en`/`wr_addr`/`wr_data`. Address 0 takes the mode in bits [1:0] and the group mask in bits [2+:NCH]. Address 1 sets the live spacing directly from bits [3:0]. Address 2 stages a new spacing from bits [3:0]. Address 3 with bit 0 set raises the ready bit, and writing 0 there has no effect.
- R3: In modes 1 and 2 with a non-empty group, a 4-bit period count rises by one on each `period_end`. When `period_end` arrives while the count equals the live spacing, that cycle is a boundary and the count restarts at 0. Boundaries therefore fall every spacing+1 periods.
- R4: In mode 2, `upd_strobe` pulses after every boundary, whatever the ready bit holds.
- R5: In mode 1, `upd_strobe` pulses after a boundary only if the ready bit is set, and that pulse clears the bit. A boundary with the bit clear gives no pulse.
- R6: In mode 0, `upd_strobe` pulses after the first `period_end` that finds the ready bit set, and that pulse clears the bit.
- R7: A write to address 2 marks the staged value pending. At the next boundary the staged value becomes the live spacing, the pending mark clears and `reload` pulses. The new spacing governs the count after that boundary.
- R8: Several writes to address 2 between two boundaries leave only the last value to be taken over.
- R9: A boundary with nothing pending keeps the live spacing and gives no `reload` pulse.
- R10: A write to address 2 in the same cycle as a boundary does not take part in that transfer. The earlier staged value is taken over, and the new value stays pending for the next boundary.
- R11: In mode 0 or mode 3, or with an empty group, the period count is held at 0, no boundary occurs and a staged value stays pending without transfer. Mode 3 gives no `upd_strobe` at all.
- R12: Both outputs are registered one-cycle pulses, seen in the cycle after the `period_end` that caused them, and they are low after any cycle without `period_end`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register select |
| wr_data | input | DATA_W (8) | Write data |
| period_end | input | 1 | One-cycle strobe at the end of each PWM period |
| upd_strobe | output | 1 | Handover of new duty-cycle values to the group |
| reload | output | 1 | Staged spacing was taken over as the live spacing |

## Verification
Two functions can fall in the same cycle: software staging a new spacing, and a boundary transferring the spacing that was staged before. The bench keeps its own count of periods and spacing. It issues the staging write in exactly the `period_end` cycle that its model marks as a boundary. The design passes if `reload` pulses for the older value, if the following boundaries are spaced by that older value, and if the newer value is taken over only at the boundary after that.

// File: rtl/uprd_pkg.sv
package uprd_pkg;

    localparam int UPRD_UPR_W  = 4;
    localparam int UPRD_ADDR_W = 2;

    localparam logic [UPRD_ADDR_W-1:0] ADDR_MODE = 2'd0;
    localparam logic [UPRD_ADDR_W-1:0] ADDR_SPAN = 2'd1;
    localparam logic [UPRD_ADDR_W-1:0] ADDR_NEXT = 2'd2;
    localparam logic [UPRD_ADDR_W-1:0] ADDR_CTRL = 2'd3;

    typedef enum logic [1:0] {
        UPD_MANUAL = 2'd0,
        UPD_SEMI   = 2'd1,
        UPD_AUTO   = 2'd2,
        UPD_RSVD   = 2'd3
    } upd_mode_e;

    typedef struct packed {
        logic                  wr;
        logic [UPRD_UPR_W-1:0] val;
    } span_wr_t;

    function automatic logic uprd_counting(upd_mode_e m);
        return (m == UPD_SEMI) || (m == UPD_AUTO);
    endfunction

    function automatic logic uprd_self_clear(upd_mode_e m);
        return (m == UPD_MANUAL) || (m == UPD_SEMI);
    endfunction

endpackage

// File: rtl/uprd_regs.sv
module uprd_regs
    import uprd_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [UPRD_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   clr_ready,
    output upd_mode_e              mode,
    output logic                   group_any,
    output logic                   ready,
    output span_wr_t               span_wr,
    output span_wr_t               next_wr
);

    localparam int MASK_LSB = 2;
    localparam int USED_W   = MASK_LSB + NCH;

    logic [NCH-1:0] mask_q;
    upd_mode_e      mode_q;
    logic           ready_q;
    logic           set_ready;

    generate
        if (DATA_W > USED_W) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^wr_data[DATA_W-1:USED_W];
        end
    endgenerate

    assign set_ready = wr_en && (wr_addr == ADDR_CTRL) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= UPD_MANUAL;
            mask_q  <= '0;
            ready_q <= 1'b0;
        end else begin
            if (wr_en && (wr_addr == ADDR_MODE)) begin
                mode_q <= upd_mode_e'(wr_data[1:0]);
                mask_q <= wr_data[MASK_LSB +: NCH];
            end
            if (set_ready) begin
                ready_q <= 1'b1;
            end else if (clr_ready) begin
                ready_q <= 1'b0;
            end
        end
    end

    assign mode        = mode_q;
    assign group_any   = |mask_q;
    assign ready       = ready_q;
    assign span_wr.wr  = wr_en && (wr_addr == ADDR_SPAN);
    assign span_wr.val = wr_data[UPRD_UPR_W-1:0];
    assign next_wr.wr  = wr_en && (wr_addr == ADDR_NEXT);
    assign next_wr.val = wr_data[UPRD_UPR_W-1:0];

    // R5
    ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_ready && !set_ready) |=> !ready_q);

endmodule

// File: rtl/uprd_timer.sv
module uprd_timer
    import uprd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     count_en,
    input  logic     period_end,
    input  span_wr_t span_wr,
    input  span_wr_t next_wr,
    output logic     boundary,
    output logic     reload
);

    logic [UPRD_UPR_W-1:0] cnt_q;
    logic [UPRD_UPR_W-1:0] live_q;
    logic [UPRD_UPR_W-1:0] stage_q;
    logic                  pend_q;
    logic                  reload_q;
    logic                  take;

    assign boundary = count_en && period_end && (cnt_q == live_q);
    assign take     = boundary && pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            live_q   <= '0;
            stage_q  <= '0;
            pend_q   <= 1'b0;
            reload_q <= 1'b0;
        end else begin
            reload_q <= take;

            if (!count_en || boundary) begin
                cnt_q <= '0;
            end else if (period_end) begin
                cnt_q <= cnt_q + 1'b1;
            end

            if (take) begin
                live_q <= stage_q;
            end else if (span_wr.wr) begin
                live_q <= span_wr.val;
            end

            if (next_wr.wr) begin
                stage_q <= next_wr.val;
                pend_q  <= 1'b1;
            end else if (take) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign reload = reload_q;

    // R3
    cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (cnt_q == '0));

    // R7
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        next_wr.wr |=> pend_q);

    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary && pend_q && !next_wr.wr) |=> (!pend_q && reload));

    // R11
    held_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !count_en |=> (cnt_q == '0));

    // R12
    reload_after_end_chk: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> !reload);

endmodule

// File: rtl/uprd_ctrl.sv
module uprd_ctrl
    import uprd_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [UPRD_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   period_end,
    output logic                   upd_strobe,
    output logic                   reload
);

    upd_mode_e mode;
    logic      group_any;
    logic      ready;
    span_wr_t  span_wr;
    span_wr_t  next_wr;
    logic      count_en;
    logic      boundary;
    logic      fire;
    logic      clr_ready;
    logic      strobe_q;

    uprd_regs #(.NCH(NCH), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .clr_ready (clr_ready),
        .mode      (mode),
        .group_any (group_any),
        .ready     (ready),
        .span_wr   (span_wr),
        .next_wr   (next_wr)
    );

    assign count_en = uprd_counting(mode) && group_any;

    uprd_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .count_en   (count_en),
        .period_end (period_end),
        .span_wr    (span_wr),
        .next_wr    (next_wr),
        .boundary   (boundary),
        .reload     (reload)
    );

    always_comb begin
        case (mode)
            UPD_MANUAL: fire = period_end && ready;
            UPD_SEMI:   fire = boundary && ready;
            UPD_AUTO:   fire = boundary;
            default:    fire = 1'b0;
        endcase
    end

    assign clr_ready = fire && uprd_self_clear(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= fire;
        end
    end

    assign upd_strobe = strobe_q;

    // R12
    strobe_after_end_chk: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> !upd_strobe);

    // R4
    auto_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == UPD_AUTO && boundary) |=> upd_strobe);

    // R11
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == UPD_RSVD) |=> !upd_strobe);

endmodule

// File: tb/test_uprd_ctrl.sv
`timescale 1ns/1ps
module test_uprd_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       period_end = 1'b0;
    logic       upd_strobe;
    logic       reload;

    int checks = 0;
    int errors = 0;

    // bench model, built from the requirements
    logic [1:0] m_mode;
    logic [3:0] m_mask;
    logic       m_rdy;
    logic [3:0] m_cnt;
    logic [3:0] m_live;
    logic [3:0] m_stage;
    logic       m_pend;

    always #2.5 clk = ~clk;

    uprd_ctrl #(.NCH(4), .DATA_W(8)) i_uprd_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .period_end (period_end),
        .upd_strobe (upd_strobe),
        .reload     (reload)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick(input logic pe, input logic w, input logic [1:0] a,
                        input logic [7:0] d, input string tag);
        logic counting, bnd, fire, take;
        period_end = pe;
        wr_en      = w;
        wr_addr    = a;
        wr_data    = d;
        @(posedge clk);
        counting = ((m_mode == 2'd1) || (m_mode == 2'd2)) && (m_mask != 4'd0);
        bnd  = pe && counting && (m_cnt == m_live);
        case (m_mode)
            2'd0:    fire = pe && m_rdy;
            2'd1:    fire = bnd && m_rdy;
            2'd2:    fire = bnd;
            default: fire = 1'b0;
        endcase
        take = bnd && m_pend;
        if (!counting || bnd) m_cnt = 4'd0;
        else if (pe) m_cnt = m_cnt + 4'd1;
        if (take) m_live = m_stage;
        else if (w && a == 2'd1) m_live = d[3:0];
        if (w && a == 2'd2) begin
            m_stage = d[3:0];
            m_pend  = 1'b1;
        end else if (take) begin
            m_pend = 1'b0;
        end
        if (w && a == 2'd3 && d[0]) m_rdy = 1'b1;
        else if (fire && (m_mode == 2'd0 || m_mode == 2'd1)) m_rdy = 1'b0;
        if (w && a == 2'd0) begin
            m_mode = d[1:0];
            m_mask = d[5:2];
        end
        #1;
        check(tag, "upd_strobe", upd_strobe, fire);
        check(tag, "reload", reload, take);
        period_end = 1'b0;
        wr_en      = 1'b0;
    endtask

    task automatic run_periods(input int n, input logic gap, input string tag);
        for (int i = 0; i < n; i++) begin
            tick(1'b1, 1'b0, 2'd0, 8'd0, tag);
            if (gap && (i % 2 == 0)) tick(1'b0, 1'b0, 2'd0, 8'd0, "R12");
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        tick(1'b0, 1'b1, a, d, tag);
    endtask

    int strobes;

    initial begin
        m_mode = 2'd0; m_mask = '0; m_rdy = 1'b0; m_cnt = '0;
        m_live = '0; m_stage = '0; m_pend = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1", "upd_strobe after reset", upd_strobe, 1'b0);
        check("R1", "reload after reset", reload, 1'b0);
        run_periods(2, 1'b0, "R1");

        // R6: manual mode
        wr(2'd3, 8'h01, "R6");
        run_periods(2, 1'b0, "R6");
        wr(2'd3, 8'h00, "R2");
        run_periods(1, 1'b0, "R2");

        // R11: staged value not taken in mode 0 or with empty group
        wr(2'd2, 8'h05, "R11");
        run_periods(3, 1'b0, "R11");
        wr(2'd0, 8'h02, "R11");
        run_periods(3, 1'b1, "R11");
        wr(2'd0, 8'h0A, "R7");
        run_periods(8, 1'b0, "R7");

        // R3 R4 R7: sweep every spacing
        for (int v = 0; v < 16; v++) begin
            wr(2'd2, 8'(v), "R7");
            run_periods(36, (v % 3 == 0), "R3");
        end

        // R8: last staged value wins
        wr(2'd2, 8'h02, "R8");
        wr(2'd2, 8'h09, "R8");
        run_periods(30, 1'b0, "R8");

        // R9: no staged value
        run_periods(25, 1'b0, "R9");

        // R10: staging write in the boundary cycle
        wr(2'd2, 8'h01, "R10");
        while (!(m_cnt == m_live)) tick(1'b1, 1'b0, 2'd0, 8'd0, "R10");
        check("R10", "model pending before boundary", m_pend, 1'b1);
        tick(1'b1, 1'b1, 2'd2, 8'h04, "R10");
        run_periods(16, 1'b0, "R10");

        // R2: direct write of the live spacing
        wr(2'd1, 8'h03, "R2");
        run_periods(24, 1'b0, "R2");

        // R5: semi-automatic mode
        wr(2'd0, 8'h11, "R5");
        run_periods(12, 1'b0, "R5");
        wr(2'd3, 8'h01, "R5");
        strobes = 0;
        for (int i = 0; i < 12; i++) begin
            tick(1'b1, 1'b0, 2'd0, 8'd0, "R5");
            if (upd_strobe) strobes++;
        end
        check("R5", "single strobe per ready", (strobes == 1), 1'b1);

        // R11: reserved mode stays quiet
        wr(2'd3, 8'h01, "R11");
        wr(2'd2, 8'h02, "R11");
        wr(2'd0, 8'h0F, "R11");
        run_periods(6, 1'b1, "R11");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule